// File: doc/BRIEF.md
# AXI Address-Issue Ordering Gate

The gate stands between a simple request source and the read and write address channels of an AXI4 manager port. The read and write request paths are independent. Each request carries an address, an ID and two ordering flags. The gate decides cycle by cycle whether that request may be presented on its address channel. Requests that stay on one channel, keep one ID and go to one target are delivered in order by the fabric, so the gate lets them through back to back.

Ordering that the fabric does not provide has to be made by waiting for responses. A read and a write with the same ID have no ordering between them. Same-ID requests sent to different targets may also overtake each other. When a request asks for one of these orderings, the gate holds it until the earlier requests concerned have returned their responses. For reads this means the final data beat. For writes this means the write response handshake.

The gate keeps one outstanding counter for each direction. It also keeps a small record for each ID and direction: how many requests are outstanding and which target they went to. The target of a request is the top `TGT_W` bits of its address.

Top module: `axi_order_gate`

## Requirements
- R1: After reset both address channels are idle (`ar_valid`=0, `aw_valid`=0) and all counts are zero, so the first request of either kind is presented in the cycle it arrives.
- R2: Reads with one ID to one target are presented on consecutive cycles without a stall cycle, and `ar_addr`/`ar_id` equal the request's address and ID.
- R3: Writes with one ID to one target are presented on consecutive cycles without a stall cycle, and `aw_addr`/`aw_id` equal the request's address and ID.
- R4: A read with `rd_req_after_wr`=1 is held while any write is outstanding, meaning it has been accepted on AW and its B handshake has not yet happened.
- R5: A write with `wr_req_after_rd`=1 is held while any read is outstanding. Only an R handshake with `r_last`=1 completes a read; a beat with `r_last`=0 releases nothing.
- R6: An ID match across directions never holds a request. A request without its cross-direction flag is presented even when the other channel has outstanding requests with the same ID.
- R7: A request with its target flag set is held while a same-ID request on its own channel is outstanding to a different target, where target = `addr[ADDR_W-1 -: TGT_W]`. The flag does not hold a request when the outstanding same-ID requests go to the same target (any address) or when only other IDs are outstanding.
- R8: Each direction allows at most `MAX_OUT` (default 8) outstanding requests. At the limit, further requests on that direction are held until a completion frees a slot.
- R9: Suppose the outstanding same-ID requests on a channel span more than one target. Then a target-flagged request with that ID is held until all of them have completed, even if its own target matches one of them.
- R10: While a request is held, the valid signal toward the manager and the ready signal toward the requester are both 0. Once `ar_valid`/`aw_valid` has been raised, it stays 1 until accepted, even if a request that becomes outstanding afterwards would now gate it.
- R11: A completion in cycle C makes a held request eligible only from cycle C+1. An issue and a completion on the same channel in the same cycle leave that channel's count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | Read request present |
| rd_req_ready | output | 1 | Read request accepted (AR handshake) |
| rd_req_addr | input | ADDR_W | Read address |
| rd_req_id | input | ID_W | Read ID |
| rd_req_after_wr | input | 1 | Order after all outstanding writes |
| rd_req_after_tgt | input | 1 | Order after same-ID reads to other targets |
| wr_req_valid | input | 1 | Write request present |
| wr_req_ready | output | 1 | Write request accepted (AW handshake) |
| wr_req_addr | input | ADDR_W | Write address |
| wr_req_id | input | ID_W | Write ID |
| wr_req_after_rd | input | 1 | Order after all outstanding reads |
| wr_req_after_tgt | input | 1 | Order after same-ID writes to other targets |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | ADDR_W | Read address |
| ar_id | output | ID_W | Read ID |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | ADDR_W | Write address |
| aw_id | output | ID_W | Write ID |
| r_valid | input | 1 | Read data valid (observed) |
| r_ready | input | 1 | Read data ready (observed) |
| r_last | input | 1 | Final read beat (observed) |
| r_id | input | ID_W | Read data ID (observed) |
| b_valid | input | 1 | Write response valid (observed) |
| b_ready | input | 1 | Write response ready (observed) |
| b_id | input | ID_W | Write response ID (observed) |

## Verification
The hardest case to produce from the ports is an address channel whose valid is already up while a write on the other channel is accepted in the very same cycle. That accepted write would, a cycle later, make the waiting read ineligible. The bench produces it by holding `ar_ready` low while a cross-ordered read and an unflagged write are presented together. It then checks that `ar_valid` holds through the next cycle.

The same-cycle cases are reached through a counter-limit sequence. First a response is driven while a held request waits. Then a new read is issued together with a final beat one below the limit. The following issues show whether the count drifted. A sweep over prior-request kind, ID match, target match and both flags covers the gating decision for both directions.

// File: rtl/axi_order_gate.sv
module axi_order_gate #(
  parameter int ADDR_W  = 16,
  parameter int ID_W    = 2,
  parameter int TGT_W   = 2,
  parameter int MAX_OUT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_req_addr,
  input  logic [ID_W-1:0]   rd_req_id,
  input  logic              rd_req_after_wr,
  input  logic              rd_req_after_tgt,
  input  logic              wr_req_valid,
  output logic              wr_req_ready,
  input  logic [ADDR_W-1:0] wr_req_addr,
  input  logic [ID_W-1:0]   wr_req_id,
  input  logic              wr_req_after_rd,
  input  logic              wr_req_after_tgt,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [ID_W-1:0]   ar_id,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic              r_last,
  input  logic [ID_W-1:0]   r_id,
  input  logic              b_valid,
  input  logic              b_ready,
  input  logic [ID_W-1:0]   b_id
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);
  localparam int NUM_ID = 1 << ID_W;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OUT);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] rd_cnt, wr_cnt;
  logic [CNT_W-1:0] rd_idc [NUM_ID];
  logic [CNT_W-1:0] wr_idc [NUM_ID];
  logic [CNT_W-1:0] rd_left [NUM_ID];
  logic [CNT_W-1:0] wr_left [NUM_ID];
  logic [TGT_W-1:0] rd_tgt [NUM_ID];
  logic [TGT_W-1:0] wr_tgt [NUM_ID];
  logic [NUM_ID-1:0] rd_mix, wr_mix;
  logic ar_lock, aw_lock;

  wire [TGT_W-1:0] rd_new_tgt = rd_req_addr[ADDR_W-1 -: TGT_W];
  wire [TGT_W-1:0] wr_new_tgt = wr_req_addr[ADDR_W-1 -: TGT_W];
  wire rd_issue = ar_valid & ar_ready;
  wire wr_issue = aw_valid & aw_ready;
  wire rd_done  = r_valid & r_ready & r_last;
  wire wr_done  = b_valid & b_ready;

  wire rd_same_ok = (rd_idc[rd_req_id] == '0) ||
                    (!rd_mix[rd_req_id] && rd_tgt[rd_req_id] == rd_new_tgt);
  wire wr_same_ok = (wr_idc[wr_req_id] == '0) ||
                    (!wr_mix[wr_req_id] && wr_tgt[wr_req_id] == wr_new_tgt);
  wire rd_ok = (rd_cnt != CNT_MAX) && (!rd_req_after_wr || wr_cnt == '0) &&
               (!rd_req_after_tgt || rd_same_ok);
  wire wr_ok = (wr_cnt != CNT_MAX) && (!wr_req_after_rd || rd_cnt == '0) &&
               (!wr_req_after_tgt || wr_same_ok);

  assign ar_valid     = rd_req_valid & (rd_ok | ar_lock);
  assign aw_valid     = wr_req_valid & (wr_ok | aw_lock);
  assign rd_req_ready = ar_valid & ar_ready;
  assign wr_req_ready = aw_valid & aw_ready;
  assign ar_addr      = rd_req_addr;
  assign ar_id        = rd_req_id;
  assign aw_addr      = wr_req_addr;
  assign aw_id        = wr_req_id;

  always_comb begin
    for (int i = 0; i < NUM_ID; i++) begin
      rd_left[i] = rd_idc[i] - ((rd_done && r_id == ID_W'(i)) ? CNT_ONE : '0);
      wr_left[i] = wr_idc[i] - ((wr_done && b_id == ID_W'(i)) ? CNT_ONE : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt  <= '0;
      wr_cnt  <= '0;
      ar_lock <= 1'b0;
      aw_lock <= 1'b0;
    end else begin
      rd_cnt  <= rd_cnt + (rd_issue ? CNT_ONE : '0) - (rd_done ? CNT_ONE : '0);
      wr_cnt  <= wr_cnt + (wr_issue ? CNT_ONE : '0) - (wr_done ? CNT_ONE : '0);
      ar_lock <= ar_valid & ~ar_ready;
      aw_lock <= aw_valid & ~aw_ready;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ID; i++) begin
      if (!rst_n) begin
        rd_idc[i] <= '0;
        rd_tgt[i] <= '0;
        rd_mix[i] <= 1'b0;
      end else if (rd_issue && rd_req_id == ID_W'(i)) begin
        rd_idc[i] <= rd_left[i] + CNT_ONE;
        if (rd_left[i] == '0) begin
          rd_tgt[i] <= rd_new_tgt;
          rd_mix[i] <= 1'b0;
        end else if (rd_tgt[i] != rd_new_tgt) begin
          rd_mix[i] <= 1'b1;
        end
      end else begin
        rd_idc[i] <= rd_left[i];
        if (rd_left[i] == '0) rd_mix[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ID; i++) begin
      if (!rst_n) begin
        wr_idc[i] <= '0;
        wr_tgt[i] <= '0;
        wr_mix[i] <= 1'b0;
      end else if (wr_issue && wr_req_id == ID_W'(i)) begin
        wr_idc[i] <= wr_left[i] + CNT_ONE;
        if (wr_left[i] == '0) begin
          wr_tgt[i] <= wr_new_tgt;
          wr_mix[i] <= 1'b0;
        end else if (wr_tgt[i] != wr_new_tgt) begin
          wr_mix[i] <= 1'b1;
        end
      end else begin
        wr_idc[i] <= wr_left[i];
        if (wr_left[i] == '0) wr_mix[i] <= 1'b0;
      end
    end
  end

  logic [CNT_W-1:0] rd_sum, wr_sum;
  always_comb begin
    rd_sum = '0;
    wr_sum = '0;
    for (int i = 0; i < NUM_ID; i++) begin
      rd_sum = rd_sum + rd_idc[i];
      wr_sum = wr_sum + wr_idc[i];
    end
  end

  assert_ar_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready && rd_req_valid) |=> (ar_valid || !rd_req_valid));
  assert_aw_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready && wr_req_valid) |=> (aw_valid || !wr_req_valid));
  assert_rd_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && rd_cnt == CNT_MAX - CNT_ONE && !rd_done) |=> !ar_valid);
  assert_wr_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_issue && wr_cnt == CNT_MAX - CNT_ONE && !wr_done) |=> !aw_valid);
  assert_rd_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt == rd_sum);
  assert_wr_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt == wr_sum);
  assert_rd_after_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_lock && rd_req_after_wr) |-> wr_cnt == '0);
  assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_lock && wr_req_after_rd) |-> rd_cnt == '0);
endmodule

// File: tb/sim_axi_order_gate.sv
module sim_axi_order_gate;
  localparam int AW = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req_valid = 0, rd_req_after_wr = 0, rd_req_after_tgt = 0;
  logic [AW-1:0] rd_req_addr = '0;
  logic [IW-1:0] rd_req_id = '0;
  logic wr_req_valid = 0, wr_req_after_rd = 0, wr_req_after_tgt = 0;
  logic [AW-1:0] wr_req_addr = '0;
  logic [IW-1:0] wr_req_id = '0;
  logic ar_ready = 1, aw_ready = 1;
  logic r_valid = 0, r_ready = 1, r_last = 0, b_valid = 0, b_ready = 1;
  logic [IW-1:0] r_id = '0, b_id = '0;
  logic rd_req_ready, wr_req_ready, ar_valid, aw_valid;
  logic [AW-1:0] ar_addr, aw_addr;
  logic [IW-1:0] ar_id, aw_id;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  axi_order_gate #(.ADDR_W(AW), .ID_W(IW), .TGT_W(2), .MAX_OUT(8)) u0 (
    .clk, .rst_n, .rd_req_valid, .rd_req_ready, .rd_req_addr, .rd_req_id,
    .rd_req_after_wr, .rd_req_after_tgt, .wr_req_valid, .wr_req_ready,
    .wr_req_addr, .wr_req_id, .wr_req_after_rd, .wr_req_after_tgt,
    .ar_valid, .ar_ready, .ar_addr, .ar_id, .aw_valid, .aw_ready, .aw_addr,
    .aw_id, .r_valid, .r_ready, .r_last, .r_id, .b_valid, .b_ready, .b_id);

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input bit wr, input logic [AW-1:0] a, input logic [IW-1:0] id,
                     input bit fa, input bit ft);
    if (wr) begin
      wr_req_valid = 1; wr_req_addr = a; wr_req_id = id;
      wr_req_after_rd = fa; wr_req_after_tgt = ft;
    end else begin
      rd_req_valid = 1; rd_req_addr = a; rd_req_id = id;
      rd_req_after_wr = fa; rd_req_after_tgt = ft;
    end
  endtask

  task automatic drop(input bit wr);
    if (wr) wr_req_valid = 0; else rd_req_valid = 0;
  endtask

  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [IW-1:0] id);
    put(wr, a, id, 0, 0);
    cyc();
    drop(wr);
  endtask

  task automatic resp(input bit wr, input logic [IW-1:0] id, input bit last);
    if (wr) begin b_valid = 1; b_id = id; end
    else begin r_valid = 1; r_id = id; r_last = last; end
    cyc();
    b_valid = 0; r_valid = 0; r_last = 0;
  endtask

  task automatic run_case(input bit wr, input int prior, input bit sid, input bit stgt,
                          input bit fa, input bit ft);
    logic [IW-1:0] pid;
    logic [AW-1:0] paddr, taddr;
    bit hold, v, rdy;
    int opp, same;
    string tag;
    pid   = sid ? 2'd1 : 2'd2;
    paddr = {(stgt ? 2'b01 : 2'b10), 14'h0123};
    taddr = {2'b01, 14'h0456};
    opp   = wr ? 1 : 2;
    same  = wr ? 2 : 1;
    if (prior == 1) send(0, paddr, pid);
    if (prior == 2) send(1, paddr, pid);
    hold = (prior == opp && fa) || (prior == same && ft && sid && !stgt);
    if (hold) tag = (prior == opp) ? (wr ? "R5 held after reads" : "R4 held after writes")
                                   : "R7 held other target";
    else if (prior == opp) tag = "R6 id match across channels";
    else if (prior == same) tag = wr ? "R3 write not held" : "R2 read not held";
    else tag = "R1 idle gate passes";
    put(wr, taddr, 2'd1, fa, ft);
    #1;
    v   = wr ? aw_valid : ar_valid;
    rdy = wr ? wr_req_ready : rd_req_ready;
    chk(v, !hold, tag);
    chk(rdy, !hold, "R10 requester ready");
    if (!hold) begin
      chk(wr ? aw_addr : ar_addr, taddr, wr ? "R3 addr pass" : "R2 addr pass");
      chk(wr ? aw_id : ar_id, 1, wr ? "R3 id pass" : "R2 id pass");
      cyc();
      drop(wr);
      if (prior != 0) resp(prior == 2, pid, 1);
    end else begin
      cyc();
      #1;
      chk(wr ? aw_valid : ar_valid, 0, "R10 still held");
      @(negedge clk);
      if (prior == 2) begin b_valid = 1; b_id = pid; end
      else begin r_valid = 1; r_id = pid; r_last = 1; end
      #1;
      chk(wr ? aw_valid : ar_valid, 0, "R11 not same cycle");
      @(negedge clk);
      b_valid = 0; r_valid = 0; r_last = 0;
      #1;
      chk(wr ? aw_valid : ar_valid, 1, "R11 released next cycle");
      cyc();
      drop(wr);
    end
    resp(wr, 2'd1, 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    chk(ar_valid, 0, "R1 ar idle in reset");
    chk(aw_valid, 0, "R1 aw idle in reset");
    rst_n = 1;
    @(negedge clk);
    #1;
    chk(ar_valid, 0, "R1 ar idle");
    chk(aw_valid, 0, "R1 aw idle");
    @(negedge clk);

    for (int w = 0; w < 2; w++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++)
          for (int t = 0; t < 2; t++)
            for (int f = 0; f < 4; f++)
              run_case(w[0], p, s[0], t[0], f[1], f[0]);

    // R5: non-final beats release nothing
    send(0, 16'h4000, 2'd3);
    put(1, 16'h4010, 2'd3, 1, 0);
    #1; chk(aw_valid, 0, "R5 held before beats");
    @(negedge clk);
    resp(0, 2'd3, 0);
    #1; chk(aw_valid, 0, "R5 non-last beat");
    @(negedge clk);
    resp(0, 2'd3, 1);
    #1; chk(aw_valid, 1, "R5 after last beat");
    cyc(); drop(1);
    resp(1, 2'd3, 1);

    // R7: same target, different address, not held
    send(0, 16'h4000, 2'd1);
    send(0, 16'h4abc, 2'd1);
    put(0, 16'h7fff, 2'd1, 0, 1);
    #1; chk(ar_valid, 1, "R7 same target not held");
    cyc(); drop(0);
    for (int k = 0; k < 3; k++) resp(0, 2'd1, 1);

    // R9: mixed targets hold until all done
    send(0, 16'h4000, 2'd1);
    send(0, 16'h8000, 2'd1);
    put(0, 16'h4100, 2'd1, 0, 1);
    #1; chk(ar_valid, 0, "R9 mixed held");
    @(negedge clk);
    resp(0, 2'd1, 1);
    #1; chk(ar_valid, 0, "R9 one left still held");
    @(negedge clk);
    resp(0, 2'd1, 1);
    #1; chk(ar_valid, 1, "R9 released");
    cyc(); drop(0);
    resp(0, 2'd1, 1);

    // R8 limit, R2 back to back, R11 same-cycle issue and completion
    put(0, 16'h0040, 2'd0, 0, 0);
    for (int k = 0; k < 8; k++) begin
      #1; chk(ar_valid, 1, "R2 back to back");
      @(negedge clk);
    end
    #1; chk(ar_valid, 0, "R8 limit holds");
    chk(rd_req_ready, 0, "R8 limit ready low");
    @(negedge clk);
    r_valid = 1; r_last = 1; r_id = 0;
    #1; chk(ar_valid, 0, "R11 limit not same cycle");
    @(negedge clk);
    r_valid = 0; r_last = 0;
    #1; chk(ar_valid, 1, "R8 slot freed");
    cyc();
    #1; chk(ar_valid, 0, "R8 full again");
    @(negedge clk);
    drop(0);
    resp(0, 2'd0, 1);
    put(0, 16'h0040, 2'd0, 0, 0);
    r_valid = 1; r_last = 1; r_id = 0;
    #1; chk(ar_valid, 1, "R11 issue with completion");
    @(negedge clk);
    r_valid = 0; r_last = 0;
    #1; chk(ar_valid, 1, "R11 count unchanged");
    @(negedge clk);
    #1; chk(ar_valid, 0, "R11 exact limit reached");
    @(negedge clk);
    drop(0);
    for (int k = 0; k < 8; k++) resp(0, 2'd0, 1);

    // R10: presented valid stays up when a write slips in
    ar_ready = 0;
    put(0, 16'h1000, 2'd2, 1, 0);
    put(1, 16'h1000, 2'd2, 0, 0);
    #1; chk(ar_valid, 1, "R10 read presented");
    chk(aw_valid, 1, "R6 write presented");
    @(negedge clk);
    drop(1);
    #1; chk(ar_valid, 1, "R10 valid kept");
    @(negedge clk);
    #1; chk(ar_valid, 1, "R10 valid kept again");
    ar_ready = 1;
    @(negedge clk);
    drop(0);
    resp(0, 2'd2, 1);
    resp(1, 2'd2, 1);
    put(0, 16'h1000, 2'd2, 1, 1);
    #1; chk(ar_valid, 1, "R4 drained gate passes");
    cyc(); drop(0);
    resp(0, 2'd2, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule